// File: doc/BRIEF.md
# Clock Output Mode Selector

This block sits between the frequency synthesis stage and the output pads of a system clock generator. A 2-bit operating-mode field picks what every output group carries. Tri-state mode drops every output enable and holds the outputs low. Test mode sends divided copies of one externally driven test clock to every group, so that each output path can be checked from a single input. Normal and modulated modes pass the synthesized clocks through. The same path also applies a per-pin select that chooses between a 48 MHz source and its 24 MHz half for each peripheral clock pin.

All clock-like inputs are treated as sampled waveforms on the block clock `clk`, which must run faster than any of them. Every input passes through two register stages before it reaches the outputs. The test-clock divider, the CPU-to-PCI halving divider and the 48-to-24 halving divider each advance on rising edges they detect inside the block. Output-enable lines are provided per group so the pad ring can tri-state them.

Top module: `clk_mode_sel`

## Requirements
- R1: The mode field encodes 00 as normal, 01 as test, 10 as modulated and 11 as tri-state. Every group output-enable is 1 in the first three modes and 0 in tri-state.
- R2: In tri-state mode every clock output bit is held at 0.
- R3: In test mode every CPU and memory bit carries the test clock divided by 2, and every PCI bit carries it divided by 4. The PCI outputs change only on a falling edge of the CPU outputs.
- R4: In test mode the reference and interrupt-controller outputs carry the sampled test clock undivided. Peripheral pin i carries the test clock divided by 2 when select bit i is 1 and divided by 4 when it is 0.
- R5: The test divider is held at zero in every mode other than test. After test mode is entered, the /2 and /4 outputs start low, and the first detected test-clock rise drives /2 high while /4 stays low.
- R6: In normal mode the memory outputs equal the CPU source and the reference and interrupt-controller outputs equal the reference source. The PCI outputs are the CPU source halved: they toggle on each CPU-source rising edge and never clear when the mode changes.
- R7: In normal mode peripheral pin i carries the 48 MHz source when select bit i is 1. When the bit is 0, the pin carries a 24 MHz copy made by toggling on each rising edge of the 48 MHz source. Each bit controls only its own pin.
- R8: Modulated mode (10) selects the same sources as normal mode and raises the modulation-enable output. That output is 0 in every other mode.
- R9: An input sampled at clock edge k appears on the outputs after edge k+2. While reset is active, every output and output-enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, faster than every sampled source |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Operating mode: 00 normal, 01 test, 10 modulated, 11 tri-state |
| fsel_i | input | N_FSEL | Per-pin peripheral select: 1 = 48 MHz, 0 = 24 MHz |
| tst_clk_i | input | 1 | Externally driven test clock |
| cpu_src_i | input | 1 | Synthesized CPU clock |
| ref_src_i | input | 1 | Buffered reference oscillator clock |
| usb_src_i | input | 1 | Synthesized 48 MHz clock |
| cpu_o | output | N_CPU | CPU clock outputs |
| cpu_oe_o | output | 1 | CPU group output enable |
| mem_o | output | N_MEM | Memory clock outputs |
| mem_oe_o | output | 1 | Memory group output enable |
| pci_o | output | N_PCI | PCI clock outputs |
| pci_oe_o | output | 1 | PCI group output enable |
| ref_o | output | N_REF | Reference clock outputs |
| ref_oe_o | output | 1 | Reference group output enable |
| apic_o | output | N_APIC | Interrupt-controller clock outputs |
| apic_oe_o | output | 1 | Interrupt-controller group output enable |
| usb_o | output | N_FSEL | 48/24 MHz peripheral clock outputs |
| usb_oe_o | output | 1 | Peripheral group output enable |
| ssc_en_o | output | 1 | Modulation enable to the synthesizer |

## Verification
The bench builds the block with its default widths: three CPU, eight memory, seven PCI, three reference, one interrupt-controller and two peripheral outputs. With two select bits, the bench can drive the 10 and 01 patterns and show that each bit steers only its own pin. Seven PCI bits and eight memory bits are wide enough to catch a replication slip within a group. The bench varies the test-clock and CPU-source periods between modes and re-enters test mode from tri-state and after very short stays elsewhere. This shows the divider clearing and the free-running PCI and 24 MHz halves across mode changes.

// File: rtl/clk_mode_pkg.sv
// Package: shared mode encoding for the clock output mode selector.
// Assumes the 2-bit field comes straight from the function-select register.
package clk_mode_pkg;

    typedef enum logic [1:0] {
        MODE_NORM = 2'b00,
        MODE_TEST = 2'b01,
        MODE_SSC  = 2'b10,
        MODE_HIZ  = 2'b11
    } omode_t;

    // Divider width needed for the deepest test ratio (divide by 4).
    localparam int unsigned TEST_DIV_W = 2;

endpackage

// File: rtl/cms_delay.sv
// Module: fixed-depth register pipeline.
// Samples a W-bit bus and presents it DEPTH clock edges later.
// Assumes synchronous active-low reset clears every stage to zero.
module cms_delay #(
    parameter int unsigned W     = 1,
    parameter int unsigned DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stage [DEPTH];

    for (genvar gs = 0; gs < DEPTH; gs++) begin : g_stage
        if (gs == 0) begin : g_first
            // Capture the input bus into the first stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[gs] <= '0;
                else        stage[gs] <= d_i;
            end
        end else begin : g_next
            // Shift the previous stage forward.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[gs] <= '0;
                else        stage[gs] <= stage[gs-1];
            end
        end
    end

    assign q_o = stage[DEPTH-1];

endmodule

// File: rtl/cms_edge_cnt.sv
// Module: clearable edge counter used as a clock divider.
// Bit b of the count is the advancing waveform divided by 2**(b+1).
// With W = 1 it is a plain toggle flip-flop. Clear has priority over advance.
module cms_edge_cnt #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         adv_i,
    output logic [W-1:0] cnt_o
);

    logic [W-1:0] cnt_q;

    // Clear, advance on a detected rise, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clr_i) cnt_q <= '0;
        else if (adv_i) cnt_q <= cnt_q + W'(1);
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/clk_mode_sel.sv
// Module: clock output mode selector (top).
// Applies the global 2-bit operating mode to every output group. Tri-state
// drops the enables, test mode routes divided copies of the test clock, and
// normal or modulated mode passes the synthesized clocks. It also applies
// the per-pin 48/24 select. Assumes clk oversamples every clock input,
// and gives a fixed two-edge latency from input sample to output.
module clk_mode_sel
    import clk_mode_pkg::*;
#(
    parameter int unsigned N_CPU  = 3,
    parameter int unsigned N_MEM  = 8,
    parameter int unsigned N_PCI  = 7,
    parameter int unsigned N_REF  = 3,
    parameter int unsigned N_APIC = 1,
    parameter int unsigned N_FSEL = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic [N_FSEL-1:0] fsel_i,
    input  logic              tst_clk_i,
    input  logic              cpu_src_i,
    input  logic              ref_src_i,
    input  logic              usb_src_i,
    output logic [N_CPU-1:0]  cpu_o,
    output logic              cpu_oe_o,
    output logic [N_MEM-1:0]  mem_o,
    output logic              mem_oe_o,
    output logic [N_PCI-1:0]  pci_o,
    output logic              pci_oe_o,
    output logic [N_REF-1:0]  ref_o,
    output logic              ref_oe_o,
    output logic [N_APIC-1:0] apic_o,
    output logic              apic_oe_o,
    output logic [N_FSEL-1:0] usb_o,
    output logic              usb_oe_o,
    output logic              ssc_en_o
);

    localparam int unsigned FAST_W = 2 + 3;       // mode plus three edge-detected clocks
    localparam int unsigned SLOW_W = N_FSEL + 1;  // selects plus reference clock
    localparam int unsigned TDW    = TEST_DIV_W;

    logic [FAST_W-1:0] fast_s1, fast_s2;
    logic [SLOW_W-1:0] slow_s2;
    logic [1:0]        mode_s1, mode_s2;
    logic              tst_s1, tst_s2, cpu_s1, cpu_s2, usb_s1, usb_s2, ref_s2;
    logic [N_FSEL-1:0] fsel_s2;
    logic              tst_rise, cpu_rise, usb_rise;
    logic [TDW-1:0]    tdiv;
    logic              pdiv, udiv;
    omode_t            sel;
    logic              is_hiz, is_test;
    logic              cpu_nxt, pci_nxt, ref_nxt, oe_nxt, ssc_nxt;
    logic [N_FSEL-1:0] usb_nxt;

    // Two sampling stages for the mode and the edge-detected clocks.
    cms_delay #(.W(FAST_W), .DEPTH(1)) u_fast_a (
        .clk(clk), .rst_n(rst_n),
        .d_i({mode_i, tst_clk_i, cpu_src_i, usb_src_i}), .q_o(fast_s1)
    );
    cms_delay #(.W(FAST_W), .DEPTH(1)) u_fast_b (
        .clk(clk), .rst_n(rst_n), .d_i(fast_s1), .q_o(fast_s2)
    );
    // Matching two-stage delay for the selects and the reference clock.
    cms_delay #(.W(SLOW_W), .DEPTH(2)) u_slow (
        .clk(clk), .rst_n(rst_n), .d_i({fsel_i, ref_src_i}), .q_o(slow_s2)
    );

    assign {mode_s1, tst_s1, cpu_s1, usb_s1} = fast_s1;
    assign {mode_s2, tst_s2, cpu_s2, usb_s2} = fast_s2;
    assign {fsel_s2, ref_s2}                 = slow_s2;

    assign tst_rise = tst_s1 & ~tst_s2;
    assign cpu_rise = cpu_s1 & ~cpu_s2;
    assign usb_rise = usb_s1 & ~usb_s2;

    // Test divider: held at zero outside test mode, counts test-clock rises inside it.
    cms_edge_cnt #(.W(TDW)) u_tdiv (
        .clk(clk), .rst_n(rst_n),
        .clr_i(mode_s1 != MODE_TEST), .adv_i(tst_rise), .cnt_o(tdiv)
    );
    // Free-running half-rate copy of the CPU source for the PCI group.
    cms_edge_cnt #(.W(1)) u_pdiv (
        .clk(clk), .rst_n(rst_n),
        .clr_i(1'b0), .adv_i(cpu_rise), .cnt_o(pdiv)
    );
    // Free-running 24 MHz copy of the 48 MHz source.
    cms_edge_cnt #(.W(1)) u_udiv (
        .clk(clk), .rst_n(rst_n),
        .clr_i(1'b0), .adv_i(usb_rise), .cnt_o(udiv)
    );

    assign sel     = omode_t'(mode_s2);
    assign is_hiz  = (sel == MODE_HIZ);
    assign is_test = (sel == MODE_TEST);

    // Pick the source of each shared-group waveform for the current mode.
    always_comb begin
        cpu_nxt = 1'b0;
        pci_nxt = 1'b0;
        ref_nxt = 1'b0;
        oe_nxt  = 1'b1;
        ssc_nxt = 1'b0;
        unique case (sel)
            MODE_HIZ: begin
                oe_nxt = 1'b0;
            end
            MODE_TEST: begin
                cpu_nxt = tdiv[0];
                pci_nxt = tdiv[1];
                ref_nxt = tst_s2;
            end
            MODE_SSC: begin
                cpu_nxt = cpu_s2;
                pci_nxt = pdiv;
                ref_nxt = ref_s2;
                ssc_nxt = 1'b1;
            end
            default: begin
                cpu_nxt = cpu_s2;
                pci_nxt = pdiv;
                ref_nxt = ref_s2;
            end
        endcase
    end

    // Per-pin peripheral source, each steered by its own select bit.
    for (genvar gu = 0; gu < N_FSEL; gu++) begin : g_usb
        assign usb_nxt[gu] = is_hiz  ? 1'b0 :
                             is_test ? (fsel_s2[gu] ? tdiv[0] : tdiv[1]) :
                                       (fsel_s2[gu] ? usb_s2  : udiv);
    end

    // Register every output group and its enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_o     <= '0;
            mem_o     <= '0;
            pci_o     <= '0;
            ref_o     <= '0;
            apic_o    <= '0;
            usb_o     <= '0;
            cpu_oe_o  <= 1'b0;
            mem_oe_o  <= 1'b0;
            pci_oe_o  <= 1'b0;
            ref_oe_o  <= 1'b0;
            apic_oe_o <= 1'b0;
            usb_oe_o  <= 1'b0;
            ssc_en_o  <= 1'b0;
        end else begin
            cpu_o     <= {N_CPU{cpu_nxt}};
            mem_o     <= {N_MEM{cpu_nxt}};
            pci_o     <= {N_PCI{pci_nxt}};
            ref_o     <= {N_REF{ref_nxt}};
            apic_o    <= {N_APIC{ref_nxt}};
            usb_o     <= usb_nxt;
            cpu_oe_o  <= oe_nxt;
            mem_oe_o  <= oe_nxt;
            pci_oe_o  <= oe_nxt;
            ref_oe_o  <= oe_nxt;
            apic_oe_o <= oe_nxt;
            usb_oe_o  <= oe_nxt;
            ssc_en_o  <= ssc_nxt;
        end
    end

endmodule

// File: rtl/cms_checker.sv
// Module: property checker for the clock output mode selector.
// Watches the top-level ports only. An age counter keeps every $past
// window inside the cycles since reset.
module cms_checker #(
    parameter int unsigned N_CPU  = 3,
    parameter int unsigned N_MEM  = 8,
    parameter int unsigned N_PCI  = 7,
    parameter int unsigned N_REF  = 3,
    parameter int unsigned N_APIC = 1,
    parameter int unsigned N_FSEL = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode_i,
    input logic [N_CPU-1:0]  cpu_o,
    input logic              cpu_oe_o,
    input logic [N_MEM-1:0]  mem_o,
    input logic              mem_oe_o,
    input logic [N_PCI-1:0]  pci_o,
    input logic              pci_oe_o,
    input logic [N_REF-1:0]  ref_o,
    input logic              ref_oe_o,
    input logic [N_APIC-1:0] apic_o,
    input logic              apic_oe_o,
    input logic [N_FSEL-1:0] usb_o,
    input logic              usb_oe_o,
    input logic              ssc_en_o
);

    logic [2:0] age;

    // Count edges since reset, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)          age <= 3'd0;
        else if (age != 3'd7) age <= age + 3'd1;
    end

    // R2: a dropped enable means every clock bit is low.
    a_r2_hiz_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_oe_o |-> (cpu_o == '0 && mem_o == '0 && pci_o == '0 &&
                       ref_o == '0 && apic_o == '0 && usb_o == '0));

    // R1: all group enables agree and follow the mode three samples back.
    a_r1_oe_follows_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 3'd5) |-> (cpu_oe_o == ($past(mode_i, 3) != 2'b11) &&
                           mem_oe_o == cpu_oe_o && pci_oe_o == cpu_oe_o &&
                           ref_oe_o == cpu_oe_o && apic_oe_o == cpu_oe_o &&
                           usb_oe_o == cpu_oe_o));

    // R8: modulation enable is high exactly in mode 10.
    a_r8_mod_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 3'd5) |-> (ssc_en_o == ($past(mode_i, 3) == 2'b10)));

    // R3: in steady test mode the /4 output moves only when /2 falls.
    a_r3_pci_on_cpu_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 3'd5 && $past(mode_i, 3) == 2'b01 && $past(mode_i, 4) == 2'b01 &&
         !$stable(pci_o[0])) |-> $fell(cpu_o[0]));

    // R6: in steady normal or modulated mode PCI moves only when CPU rises.
    a_r6_pci_on_cpu_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 3'd5 && !$past(mode_i[0], 3) && !$past(mode_i[0], 4) &&
         !$stable(pci_o[0])) |-> $rose(cpu_o[0]));

    // R4: reference and interrupt-controller groups always carry the same waveform.
    a_r4_ref_apic_agree: assert property (@(posedge clk) disable iff (!rst_n)
        apic_o[0] == ref_o[0]);

endmodule

bind clk_mode_sel cms_checker #(
    .N_CPU(N_CPU), .N_MEM(N_MEM), .N_PCI(N_PCI),
    .N_REF(N_REF), .N_APIC(N_APIC), .N_FSEL(N_FSEL)
) u_chk (.*);

// File: tb/clk_mode_sel_test.sv
`timescale 1ns/1ps
// Bench: drives mode, selects and source waveforms, and compares every output
// on every clock against a behavioural model built from the requirements.
module clk_mode_sel_test;

    localparam int N_CPU = 3, N_MEM = 8, N_PCI = 7, N_REF = 3, N_APIC = 1, N_FSEL = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] mode_i = 2'b00;
    logic [N_FSEL-1:0] fsel_i = '0;
    logic tst_clk_i = 1'b0, cpu_src_i = 1'b0, ref_src_i = 1'b0, usb_src_i = 1'b0;
    logic [N_CPU-1:0] cpu_o;
    logic [N_MEM-1:0] mem_o;
    logic [N_PCI-1:0] pci_o;
    logic [N_REF-1:0] ref_o;
    logic [N_APIC-1:0] apic_o;
    logic [N_FSEL-1:0] usb_o;
    logic cpu_oe_o, mem_oe_o, pci_oe_o, ref_oe_o, apic_oe_o, usb_oe_o, ssc_en_o;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 0;

    // Model state: input history (index 0 newest) and divider integers.
    int hm[3], ht[3], hc[3], hr[3], hu[3], hf[3];
    int tcnt = 0, pdiv = 0, udiv = 0, test_run = 0;

    always #2.5 clk = ~clk;

    clk_mode_sel #(
        .N_CPU(N_CPU), .N_MEM(N_MEM), .N_PCI(N_PCI),
        .N_REF(N_REF), .N_APIC(N_APIC), .N_FSEL(N_FSEL)
    ) uut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .fsel_i(fsel_i),
        .tst_clk_i(tst_clk_i), .cpu_src_i(cpu_src_i), .ref_src_i(ref_src_i),
        .usb_src_i(usb_src_i),
        .cpu_o(cpu_o), .cpu_oe_o(cpu_oe_o), .mem_o(mem_o), .mem_oe_o(mem_oe_o),
        .pci_o(pci_o), .pci_oe_o(pci_oe_o), .ref_o(ref_o), .ref_oe_o(ref_oe_o),
        .apic_o(apic_o), .apic_oe_o(apic_oe_o), .usb_o(usb_o), .usb_oe_o(usb_oe_o),
        .ssc_en_o(ssc_en_o)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h", tag, what, cyc, act, exp);
        end
    endtask

    function automatic logic [31:0] rep(input int bitv, input int n);
        return bitv ? ((32'd1 << n) - 32'd1) : 32'd0;
    endfunction

    // Compare after a posedge; model update uses the samples taken at that edge.
    task automatic compare_edge();
        int m2, t2, c2, r2, u2, f2;
        int e_cpu, e_pci, e_ref, e_oe;
        logic [31:0] e_usb;
        string tg_main, tg_usb;
        logic [31:0] oe_act;
        if (!rst_n) begin
            chk("R9", "cpu reset", 32'(cpu_o), 0);
            chk("R9", "pci reset", 32'(pci_o), 0);
            chk("R9", "usb reset", 32'(usb_o), 0);
            chk("R9", "oe reset", {26'd0, cpu_oe_o, mem_oe_o, pci_oe_o, ref_oe_o, apic_oe_o, usb_oe_o}, 0);
            chk("R9", "mod reset", 32'(ssc_en_o), 0);
            return;
        end
        for (int k = 2; k > 0; k--) begin
            hm[k] = hm[k-1]; ht[k] = ht[k-1]; hc[k] = hc[k-1];
            hr[k] = hr[k-1]; hu[k] = hu[k-1]; hf[k] = hf[k-1];
        end
        hm[0] = mode_i; ht[0] = tst_clk_i; hc[0] = cpu_src_i;
        hr[0] = ref_src_i; hu[0] = usb_src_i; hf[0] = fsel_i;
        m2 = hm[2]; t2 = ht[2]; c2 = hc[2]; r2 = hr[2]; u2 = hu[2]; f2 = hf[2];
        test_run = (m2 == 1) ? test_run + 1 : 0;
        e_usb = 0;
        if (m2 == 3) begin
            e_cpu = 0; e_pci = 0; e_ref = 0; e_oe = 0;
            tg_main = "R2"; tg_usb = "R2";
        end else if (m2 == 1) begin
            e_cpu = tcnt % 2; e_pci = tcnt / 2; e_ref = t2; e_oe = 1;
            for (int i = 0; i < N_FSEL; i++)
                e_usb[i] = ((f2 >> i) & 1) ? e_cpu[0] : e_pci[0];
            tg_main = (test_run < 8) ? "R5" : "R3"; tg_usb = "R4";
        end else begin
            e_cpu = c2; e_pci = pdiv; e_ref = r2; e_oe = 1;
            for (int i = 0; i < N_FSEL; i++)
                e_usb[i] = ((f2 >> i) & 1) ? u2[0] : udiv[0];
            tg_main = (m2 == 2) ? "R8" : "R6"; tg_usb = (m2 == 2) ? "R8" : "R7";
        end
        chk(tg_main, "cpu", 32'(cpu_o), rep(e_cpu, N_CPU));
        chk(tg_main, "mem", 32'(mem_o), rep(e_cpu, N_MEM));
        chk(tg_main, "pci", 32'(pci_o), rep(e_pci, N_PCI));
        chk((m2 == 1) ? "R4" : tg_main, "ref", 32'(ref_o), rep(e_ref, N_REF));
        chk((m2 == 1) ? "R4" : tg_main, "apic", 32'(apic_o), rep(e_ref, N_APIC));
        chk(tg_usb, "usb", 32'(usb_o), e_usb);
        oe_act = {26'd0, cpu_oe_o, mem_oe_o, pci_oe_o, ref_oe_o, apic_oe_o, usb_oe_o};
        chk("R1", "oe", oe_act, rep(e_oe, 6));
        chk("R8", "mod enable", 32'(ssc_en_o), (m2 == 2) ? 1 : 0);
        // Advance divider state with the rises seen one edge back.
        if (hm[1] != 1) tcnt = 0;
        else if (ht[1] == 1 && ht[2] == 0) tcnt = (tcnt + 1) % 4;
        if (hc[1] == 1 && hc[2] == 0) pdiv ^= 1;
        if (hu[1] == 1 && hu[2] == 0) udiv ^= 1;
    endtask

    task automatic run(input logic [1:0] md, input logic [N_FSEL-1:0] fs, input int n,
                       input int tper, input int cper);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            mode_i    = md;
            fsel_i    = fs;
            tst_clk_i = ((cyc / tper) % 2) != 0;
            cpu_src_i = ((cyc / cper) % 2) != 0;
            usb_src_i = ((cyc / 2) % 2) != 0;
            ref_src_i = ((cyc / 3) % 2) != 0;
            @(posedge clk);
            #1;
            compare_edge();
            cyc++;
        end
    endtask

    initial begin
        for (int k = 0; k < 3; k++) begin
            hm[k] = 0; ht[k] = 0; hc[k] = 0; hr[k] = 0; hu[k] = 0; hf[k] = 0;
        end
        // R9: reset state with the block clock running.
        repeat (4) begin
            @(posedge clk);
            #1;
            compare_edge();
        end
        @(negedge clk);
        rst_n = 1'b1;
        run(2'b00, 2'b10, 40, 1, 1);   // R6 R7: normal, pin 1 at 48, pin 0 at 24
        run(2'b00, 2'b01, 30, 2, 2);   // R7: swapped selects, slower CPU source
        run(2'b10, 2'b11, 24, 1, 2);   // R8: modulated mode
        run(2'b01, 2'b10, 40, 1, 1);   // R3 R4 R5: test entry, fast test clock
        run(2'b01, 2'b01, 30, 3, 1);   // R4: selects flipped inside test
        run(2'b11, 2'b00, 16, 1, 1);   // R1 R2: tri-state
        run(2'b01, 2'b11, 20, 2, 1);   // R5: re-entry from tri-state
        run(2'b00, 2'b10, 3, 1, 1);    // short stays to stress clearing
        run(2'b01, 2'b10, 5, 1, 1);
        run(2'b10, 2'b01, 4, 1, 3);
        run(2'b01, 2'b00, 12, 2, 1);   // R5: entry with a slower test clock
        run(2'b11, 2'b11, 5, 1, 1);    // R2
        run(2'b00, 2'b00, 30, 1, 3);   // R6 R7: PCI half of an odd-period CPU source
        run(2'b10, 2'b10, 20, 4, 1);   // R8
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #500000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired at cycle %0d: actual=running expected=finished", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule